// File: doc/BRIEF.md
# Compare Timer Channel

A single counting channel with a word-addressed register bus. A selectable clock source drives an up-counter: the core clock divided by 2, 8, 32 or 128, or rising edges of one of two asynchronous inputs (a slow reference and a chained input from a neighbouring channel). Two compare registers, A and C, watch the counter. A match on C can clear the counter, to give a programmable period, or stop the channel, to give a one-shot delay. The matches also drive a waveform pin: A sets it and C clears it, which gives a square wave or a PWM signal.

Software starts the channel through a control word. The control word has three bits: enable, disable and trigger. Trigger zeroes the counter and starts it in one write. Compare and wrap events are latched as status flags, and reading the status word clears them. An interrupt mask is changed through separate set and clear words and can be read back. The interrupt line is one level output. Bus accesses are single-cycle with no back-pressure: a request is accepted in the cycle `bus_valid` is high. Read data is returned with `bus_rvalid` one cycle later.

Register word addresses: 0 control (write), 1 mode, 2 counter (read), 3 compare A, 4 compare C, 5 status (read), 6 mask set (write), 7 mask clear (write), 8 mask (read).

Top module: `tc_channel`

## Requirements
- R1: Mode bits [3:0] select the counting clock. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 core cycles. A trigger write realigns the divider, so that after a trigger sampled at edge T the first tick for divisor N falls at edge T+N. Value 4 counts the slow input and 5 counts the chained input. Any other value gives no ticks.
- R2: With mode bit 4 clear, the counter increments on each tick while running. From all ones it wraps to zero and sets status bit 2 (overflow).
- R3: With mode bit 4 set, a tick on which the counter equals compare C loads zero instead of incrementing, so the period is C+1 ticks.
- R4: With mode bit 5 set, a tick on which the counter equals compare C also stops the channel. Status bit 16 then reads 0.
- R5: Control bit 0 starts the channel and bit 1 stops it. When both are written together, the stop wins. While stopped, the counter holds its value. Status bit 16 shows whether the channel is running.
- R6: Control bit 2 (trigger) clears the counter to zero and starts the channel. If bit 1 is set in the same write, the counter is cleared but the channel stays stopped.
- R7: A write to the mask-set word sets every mask bit written as 1. A write to the mask-clear word clears every bit written as 1, and 0xFF clears all of them. The mask-read word returns the current mask.
- R8: A status read returns the latched flags and clears them. A flag that is raised in the same cycle as the read stays set afterwards.
- R9: Mode bit 6 sets the waveform pin on a compare-A match, and mode bit 7 clears it on a compare-C match. If both match on one tick, the clear wins. On a 16-bit counter in free-running mode, with A=0 and C=0x8000, the pin is high for exactly half of each counter period.
- R10: All registers are 32 bits wide. Bits above the counter width read as zero, both in the counter and in the compare registers.
- R11: The flags are bit 0 (compare C), bit 1 (compare A) and bit 2 (overflow). The interrupt output is high while any flag has its mask bit set. The mask, the flags and the interrupt are all zero after reset.
- R12: The slow and chained inputs are synchronised, and each rising edge of the selected input gives one tick. Edges on the input that is not selected have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_in | input | 1 | Asynchronous slow reference |
| ext_clk_in | input | 1 | Asynchronous chained clock from another channel |
| bus_valid | input | 1 | Register access request, accepted in the same cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read |
| tioa | output | 1 | Compare-driven waveform output |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with a 16-bit counter and two synchroniser stages. At that width, a full wrap at the fastest divider takes about 131,000 cycles. That is within the run budget, so the overflow flag and the complete 50% square wave at A=0, C=0x8000 are both observed directly. The two-stage synchroniser gives a short, fixed delay, so the bench can count edges on the slow and chained inputs exactly with small gaps between pulses. Random trials draw each of the four divisors together with small compare values and all combinations of the auto-clear and stop bits. This keeps the period, one-shot and stop expectations short enough to check exactly.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int NUM_DIV  = 4;
  localparam int NUM_SRC  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] A_CMPA  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMPC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd5;
  localparam logic [ADDR_W-1:0] A_MSET  = 4'd6;
  localparam logic [ADDR_W-1:0] A_MCLR  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd8;

  localparam int CTL_START = 0;
  localparam int CTL_STOP  = 1;
  localparam int CTL_TRIG  = 2;

  localparam logic [3:0] SEL_SLOW = 4'(NUM_DIV);
  localparam logic [3:0] SEL_EXT  = 4'(NUM_DIV + 1);

  localparam int FLG_CMPC = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_OVF  = 2;
  localparam int STAT_RUN = 16;

  typedef struct packed {
    logic       clr_on_c;
    logic       set_on_a;
    logic       stop_on_c;
    logic       auto_clr;
    logic [3:0] clk_sel;
  } mode_t;
endpackage

// File: rtl/tc_clk_sel.sv
module tc_clk_sel
  import tc_pkg::*;
#(
  parameter int SYNC_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       realign,
  input  logic [3:0] sel,
  input  logic       slow_in,
  input  logic       ext_in,
  output logic       tick
);
  localparam int PRE_W = 2 * NUM_DIV - 1;
  localparam int IDX_W = $clog2(NUM_DIV);

  logic [PRE_W-1:0]   pre;
  logic [NUM_DIV-1:0] tap;
  logic [1:0]         async_src;
  logic [1:0]         rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre <= '0;
    else if (realign) pre <= '0;
    else              pre <= pre + 1'b1;
  end

  // divisor i is 2^(2i+1): tick when the low 2i+1 bits are all ones
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    assign tap[i] = &pre[2*i:0];
  end

  assign async_src = {ext_in, slow_in};

  for (genvar j = 0; j < 2; j++) begin : g_sync
    logic [SYNC_W:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_W-1:0], async_src[j]};
    end
    assign rise[j] = sh[SYNC_W-1] & ~sh[SYNC_W];
  end

  always_comb begin
    tick = 1'b0;
    if (sel < 4'(NUM_DIV))  tick = tap[sel[IDX_W-1:0]];
    else if (sel == SEL_SLOW) tick = rise[0];
    else if (sel == SEL_EXT)  tick = rise[1];
  end

  assert_div2_alternates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tap[0] && !realign) |=> !tap[0]);
  assert_realign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (tap == '0));
endmodule

// File: rtl/tc_counter.sv
module tc_counter
  import tc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             run_on,
  input  logic             run_off,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_c,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             wave,
  output logic             ev_c,
  output logic             ev_a,
  output logic             ev_ovf
);
  logic step, at_c, at_a, at_top, clr_now;

  assign step    = running & tick;
  assign at_c    = step && (count == cmp_c);
  assign at_a    = step && (count == cmp_a);
  assign at_top  = step && (count == {CNT_W{1'b1}});
  assign clr_now = at_c && mode.auto_clr;

  assign ev_c   = at_c;
  assign ev_a   = at_a;
  assign ev_ovf = at_top && !clr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (start)   count <= '0;
    else if (clr_now) count <= '0;
    else if (step)    count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      running <= 1'b0;
    else if (run_off)                running <= 1'b0;
    else if (start || run_on)        running <= 1'b1;
    else if (at_c && mode.stop_on_c) running <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wave <= 1'b0;
    else if (at_c && mode.clr_on_c)  wave <= 1'b0;
    else if (at_a && mode.set_on_a)  wave <= 1'b1;
  end

  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && count == {CNT_W{1'b1}}) |=> (count == '0));
  assert_auto_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && mode.auto_clr && count == cmp_c) |=> (count == '0));
  assert_stop_on_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode.stop_on_c && count == cmp_c && !start && !run_on) |=> !running);
  assert_stop_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_off |=> !running);
  assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
  assert_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !run_off) |=> (running && count == '0));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode.clr_on_c && count == cmp_c) |=> !wave);
endmodule

// File: rtl/tc_irq.sv
module tc_irq
  import tc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raise,
  input  logic               rd_clr,
  input  logic               mset_we,
  input  logic               mclr_we,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] mask,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{NUM_SRC{rd_clr}}) | raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mset_we) mask <= mask | wbits;
    else if (mclr_we) mask <= mask & ~wbits;
  end

  assign irq = |(flags & mask);

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mset_we |=> ((mask & $past(wbits)) == $past(wbits)));
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_we |=> ((mask & $past(wbits)) == '0));
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((flags & ~$past(raise)) == '0));
  assert_raise_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raise != '0) |=> ((flags & $past(raise)) == $past(raise)));
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_in,
  input  logic              ext_clk_in,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              tioa,
  output logic              irq
);
  logic we, re;
  logic ctrl_we, mset_we, mclr_we, stat_rd;
  logic start, run_on, run_off;
  mode_t mode_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_c_q, count;
  logic running, tick;
  logic ev_c, ev_a, ev_ovf;
  logic [NUM_SRC-1:0] flags, mask, raise;
  logic [DATA_W-1:0] rd_mux;
  logic [ADDR_W-1:0] rd_addr_q;

  assign we      = bus_valid && bus_write;
  assign re      = bus_valid && !bus_write;
  assign ctrl_we = we && bus_addr == A_CTRL;
  assign mset_we = we && bus_addr == A_MSET;
  assign mclr_we = we && bus_addr == A_MCLR;
  assign stat_rd = re && bus_addr == A_STAT;
  assign start   = ctrl_we && bus_wdata[CTL_TRIG];
  assign run_on  = ctrl_we && bus_wdata[CTL_START];
  assign run_off = ctrl_we && bus_wdata[CTL_STOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cmp_a_q <= '0;
      cmp_c_q <= '0;
    end else if (we) begin
      if (bus_addr == A_MODE) mode_q  <= mode_t'(bus_wdata[7:0]);
      if (bus_addr == A_CMPA) cmp_a_q <= bus_wdata[CNT_W-1:0];
      if (bus_addr == A_CMPC) cmp_c_q <= bus_wdata[CNT_W-1:0];
    end
  end

  tc_clk_sel #(.SYNC_W(SYNC_W)) u_clk_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .realign (start),
    .sel     (mode_q.clk_sel),
    .slow_in (slow_clk_in),
    .ext_in  (ext_clk_in),
    .tick    (tick)
  );

  tc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .start   (start),
    .run_on  (run_on),
    .run_off (run_off),
    .mode    (mode_q),
    .cmp_a   (cmp_a_q),
    .cmp_c   (cmp_c_q),
    .count   (count),
    .running (running),
    .wave    (tioa),
    .ev_c    (ev_c),
    .ev_a    (ev_a),
    .ev_ovf  (ev_ovf)
  );

  always_comb begin
    raise           = '0;
    raise[FLG_CMPC] = ev_c;
    raise[FLG_CMPA] = ev_a;
    raise[FLG_OVF]  = ev_ovf;
  end

  tc_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (raise),
    .rd_clr  (stat_rd),
    .mset_we (mset_we),
    .mclr_we (mclr_we),
    .wbits   (bus_wdata[NUM_SRC-1:0]),
    .flags   (flags),
    .mask    (mask),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE:  rd_mux[7:0]       = mode_q;
      A_COUNT: rd_mux[CNT_W-1:0] = count;
      A_CMPA:  rd_mux[CNT_W-1:0] = cmp_a_q;
      A_CMPC:  rd_mux[CNT_W-1:0] = cmp_c_q;
      A_STAT: begin
        rd_mux[NUM_SRC-1:0] = flags;
        rd_mux[STAT_RUN]    = running;
      end
      A_MASK:  rd_mux[NUM_SRC-1:0] = mask;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      bus_rvalid <= re;
      if (re) begin
        bus_rdata <= rd_mux;
        rd_addr_q <= bus_addr;
      end
    end
  end

  if (CNT_W < DATA_W) begin : g_upper_chk
    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && (rd_addr_q == A_COUNT || rd_addr_q == A_CMPA || rd_addr_q == A_CMPC))
      |-> (bus_rdata[DATA_W-1:CNT_W] == '0));
  end

  assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(mclr_we) && $past(bus_wdata[NUM_SRC-1:0]) == {NUM_SRC{1'b1}}) |-> 1'b0);
endmodule

// File: tb/tc_channel_test.sv
module tc_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk_in = 1'b0;
  logic        ext_clk_in = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        tioa;
  logic        irq;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tc_channel #(.CNT_W(16), .SYNC_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .slow_clk_in(slow_clk_in), .ext_clk_in(ext_clk_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tioa(tioa), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_in(input bit which, input int n);
    for (int i = 0; i < n; i++) begin
      if (which) ext_clk_in = 1'b1; else slow_clk_in = 1'b1;
      idle(4);
      if (which) ext_clk_in = 1'b0; else slow_clk_in = 1'b0;
      idle(4);
    end
  endtask

  function automatic int div_of(input int sel);
    return 2 << (2 * sel);
  endfunction

  // expected counter after a trigger, k idle cycles before the read
  function automatic int exp_count(input int k, input int n, input int c,
                                   input bit auto_c, input bit stop_c);
    int t = k / n;
    if (stop_c && t >= c + 1) return auto_c ? 0 : c + 1;
    if (auto_c) return t % (c + 1);
    return t;
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int ones;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // reset state (R11, R5)
    rd(4'd5, d); chk("R11 reset status", d, 32'h0);
    rd(4'd8, d); chk("R11 reset mask", d, 32'h0);
    rd(4'd2, d); chk("R5 reset count", d, 32'h0);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    chk("R9 reset tioa", {31'b0, tioa}, 32'h0);

    // register width (R10)
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, d); chk("R10 cmpA upper bits", d, 32'h0000_FFFF);
    wr(4'd4, 32'hABCD_1234);
    rd(4'd4, d); chk("R10 cmpC upper bits", d, 32'h0000_1234);

    // control priority and hold (R5, R6)
    wr(4'd0, 32'h3);
    rd(4'd5, d); chk("R5 stop wins over start", d[16], 1'b0);
    wr(4'd0, 32'h1);
    rd(4'd5, d); chk("R5 running after start", d[16], 1'b1);
    idle(20);
    wr(4'd0, 32'h2);
    rd(4'd2, d);
    idle(10);
    rd(4'd2, d2); chk("R5 count holds when stopped", d2, d);
    chk("R5 count advanced while running", {31'b0, d != 0}, 32'h1);
    wr(4'd0, 32'h6);
    rd(4'd2, d); chk("R6 trigger with stop clears count", d, 32'h0);
    rd(4'd5, d); chk("R6 trigger with stop stays stopped", d[16], 1'b0);

    // random trials (R1, R3, R4, R6)
    for (int it = 0; it < 24; it++) begin
      int sel = $urandom_range(0, 3);
      int c   = $urandom_range(0, 15);
      int k   = $urandom_range(1, 400);
      bit ac  = 1'($urandom_range(0, 1));
      bit sc  = 1'($urandom_range(0, 1));
      int n   = div_of(sel);
      int t2;
      wr(4'd0, 32'h2);
      wr(4'd4, c);
      wr(4'd1, sel | (32'(ac) << 4) | (32'(sc) << 5));
      wr(4'd0, 32'h5);
      idle(k);
      rd(4'd2, d);
      chk($sformatf("R1 R3 R4 R6 count sel=%0d c=%0d k=%0d auto=%0d stop=%0d", sel, c, k, ac, sc),
          d, exp_count(k, n, c, ac, sc));
      t2 = (k + 1) / n;
      rd(4'd5, d);
      chk("R4 running bit", d[16], !(sc && t2 >= c + 1));
    end

    // one-shot with mask handling (R4, R7, R8, R11)
    wr(4'd0, 32'h2);
    wr(4'd7, 32'hFF);
    rd(4'd8, d); chk("R7 mask cleared by 0xFF", d, 32'h0);
    rd(4'd5, d);
    wr(4'd4, 32'd3);
    wr(4'd1, 32'h30);
    wr(4'd0, 32'h5);
    idle(20);
    chk("R11 masked flag gives no irq", {31'b0, irq}, 32'h0);
    wr(4'd6, 32'h1);
    rd(4'd8, d); chk("R7 mask set", d, 32'h1);
    chk("R11 unmasked flag raises irq", {31'b0, irq}, 32'h1);
    rd(4'd5, d);
    chk("R4 one-shot stopped", d[16], 1'b0);
    chk("R8 compare C flag returned", d[0], 1'b1);
    chk("R8 irq drops after read", {31'b0, irq}, 32'h0);
    rd(4'd5, d); chk("R8 flag cleared by read", d[2:0], 3'b000);
    rd(4'd2, d); chk("R3 R4 one-shot count parked at zero", d, 32'h0);
    wr(4'd6, 32'h6);
    rd(4'd8, d); chk("R7 mask accumulates", d, 32'h7);
    wr(4'd7, 32'h2);
    rd(4'd8, d); chk("R7 mask clear single bit", d, 32'h5);
    wr(4'd7, 32'hFF);

    // flag raised in the cycle of a read survives (R8)
    wr(4'd4, 32'd0);
    wr(4'd1, 32'h10);
    wr(4'd0, 32'h5);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'd5;
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ones += int'(bus_rdata[0]);
    end
    bus_valid = 1'b0;
    chk("R8 same-cycle raise kept over back-to-back reads", ones, 3);
    wr(4'd0, 32'h2);

    // asynchronous sources (R12, R1)
    wr(4'd1, 32'h4);
    wr(4'd0, 32'h5);
    pulse_in(1'b0, 5);
    pulse_in(1'b1, 5);
    idle(6);
    rd(4'd2, d); chk("R12 slow input counted, chained ignored", d, 32'd5);
    wr(4'd1, 32'h5);
    wr(4'd0, 32'h5);
    pulse_in(1'b1, 7);
    pulse_in(1'b0, 3);
    idle(6);
    rd(4'd2, d); chk("R12 chained input counted, slow ignored", d, 32'd7);
    wr(4'd1, 32'h6);
    wr(4'd0, 32'h5);
    idle(300);
    rd(4'd2, d); chk("R1 unused select gives no ticks", d, 32'd0);

    // square wave and full wrap (R9, R2)
    wr(4'd0, 32'h2);
    wr(4'd3, 32'd0);
    wr(4'd4, 32'h8000);
    wr(4'd1, 32'hC0);
    rd(4'd5, d);
    wr(4'd0, 32'h5);
    idle(1);
    chk("R9 pin low before first A match", {31'b0, tioa}, 32'h0);
    idle(2);
    chk("R9 pin set on A match", {31'b0, tioa}, 32'h1);
    idle(65537 - 3);
    chk("R9 pin high just before C match", {31'b0, tioa}, 32'h1);
    idle(1);
    chk("R9 pin cleared on C match", {31'b0, tioa}, 32'h0);
    idle(131079 - 65538);
    rd(4'd5, d); chk("R2 overflow with both compare flags", d, 32'h0001_0007);
    rd(4'd2, d); chk("R2 count after wrap", d, 32'd4);
    chk("R9 pin set again after wrap", {31'b0, tioa}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule